// File: doc/BRIEF.md
# Chip-Okay Health Monitor

This block turns a handful of digital comparator flags into one health indication for a field-side input chip. It watches three supply-level flags (below the fault trip, above the clear trip, and below the brownout level) and two junction-temperature flags (warning trip and shutdown trip). From them it drives a chip-okay level, an output enable for that level's pad driver, and a high-impedance request that applies to every output pad of the chip.

The supply path is debounced against a slow tick of about 1 kHz, with different delays in the two directions. Once the supply is judged good, a fault is declared only after the low-supply flag has been seen on a programmable number of ticks (default one). Once the supply is judged bad, it is cleared only after the high-supply flag has been seen on a larger number of ticks (default six). The two trips sit at different voltages, so a supply that stays between them keeps whatever state it last had. A brownout throws away all debounce progress at once. The temperature flags take effect in the same cycle and are not filtered. The warning trip pulls chip-okay low. The shutdown trip releases every output pad, chip-okay included.

All pins are plain level signals sampled on the block clock. There is no data stream and so no handshake. The tick must be a single-cycle pulse.

Top module: `cok_monitor`

## Requirements
- R1: While reset is held and after it is released, the supply state is bad, so chip_ok is 0, chip_ok_oe is 1 and outputs_hiz is 0 until a release has completed.
- R2: With the supply good, sup_below_trip at 1 on ASSERT_TICKS consecutive tick cycles makes the supply state bad. chip_ok drops in the cycle after the clock edge that samples the last of those ticks.
- R3: With the supply bad, sup_above_clear at 1 on RELEASE_TICKS consecutive tick cycles makes the supply state good. chip_ok rises in the cycle after the edge that samples the last tick, provided no temperature flag or brownout is set.
- R4: If the flag that drives the running timer drops to 0 for any cycle before the timer expires, the tick count restarts from zero and the supply state is unchanged.
- R5: With neither supply trip flag set (the hysteresis band), the supply state holds through any number of ticks.
- R6: sup_brownout at 1 forces chip_ok to 0 in the same cycle. It sets the supply state to bad and discards any partial tick count. A later release then needs the full RELEASE_TICKS ticks.
- R7: temp_warn at 1 forces chip_ok to 0 in the same cycle and leaves the supply state untouched. chip_ok follows the supply state again as soon as the flag clears.
- R8: temp_shut at 1 sets outputs_hiz to 1 and chip_ok_oe to 0 and holds chip_ok at 0, all in the same cycle. Both pad controls return to normal in the cycle the flag clears.
- R9: Apart from brownout, the supply state changes only at a clock edge that samples tick_1khz at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1khz | input | 1 | Single-cycle pulse at about 1 kHz, the debounce time base |
| sup_below_trip | input | 1 | Supply is below the fault trip (15 V) |
| sup_above_clear | input | 1 | Supply is above the clear trip (18 V) |
| sup_brownout | input | 1 | Supply is below the operating minimum (10 V) |
| temp_warn | input | 1 | Junction temperature is above the warning trip (150 °C) |
| temp_shut | input | 1 | Junction temperature is above the shutdown trip (170 °C) |
| chip_ok | output | 1 | Health level: 1 when no supply or temperature fault is present |
| chip_ok_oe | output | 1 | Output enable for the chip_ok pad driver |
| outputs_hiz | output | 1 | Request to put every output pad of the chip in high impedance |

## Verification
The bench goes after the tick counting at both ends of each window. A timer that is off by one would raise chip_ok after five release ticks or hold it after the sixth. A timer that fails to restart after the flag drops would release early once the flag returns. A brownout pulse in the middle of a release window is the main trap: a design that clears the state but keeps the count would release after only a few further ticks. The bench also holds the supply inside the hysteresis band and raises both temperature flags while the supply is good. A design that lets a temperature flag disturb the supply state would show chip_ok stuck low after the flag clears.

// File: rtl/cok_pkg.sv
`timescale 1ns/1ps
package cok_pkg;
  // Debounced view of the supply rail.
  typedef enum logic {
    SUP_BAD  = 1'b0,
    SUP_GOOD = 1'b1
  } sup_state_e;

  localparam int unsigned COK_ASSERT_TICKS_DEF  = 1;
  localparam int unsigned COK_RELEASE_TICKS_DEF = 6;
endpackage

// File: rtl/cok_dwell_timer.sv
`timescale 1ns/1ps
// Counts ticks while a condition holds continuously and fires on the
// tick that completes the requested dwell.
module cok_dwell_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  assign expire = run && tick && (cnt_q == (limit - CNT_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr || !run || expire) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/cok_supply_tracker.sv
`timescale 1ns/1ps
// Supply state with asymmetric debounce and brownout clear.
module cok_supply_tracker
  import cok_pkg::*;
#(
  parameter int unsigned ASSERT_TICKS  = COK_ASSERT_TICKS_DEF,
  parameter int unsigned RELEASE_TICKS = COK_RELEASE_TICKS_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic below_trip,
  input  logic above_clear,
  input  logic brownout,
  output logic sup_good
);
  localparam int unsigned MAX_TICKS = (ASSERT_TICKS > RELEASE_TICKS) ? ASSERT_TICKS : RELEASE_TICKS;
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

  sup_state_e       state_q;
  logic             run;
  logic             expire;
  logic [CNT_W-1:0] limit;

  // The good state waits for the low trip, the bad state for the high one.
  always_comb begin
    if (state_q == SUP_GOOD) begin
      run   = below_trip;
      limit = CNT_W'(ASSERT_TICKS);
    end else begin
      run   = above_clear;
      limit = CNT_W'(RELEASE_TICKS);
    end
  end

  cok_dwell_timer #(.CNT_W(CNT_W)) dwell_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (brownout),
    .run    (run),
    .tick   (tick),
    .limit  (limit),
    .expire (expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SUP_BAD;
    end else if (brownout) begin
      state_q <= SUP_BAD;
    end else if (expire) begin
      state_q <= (state_q == SUP_GOOD) ? SUP_BAD : SUP_GOOD;
    end
  end

  assign sup_good = (state_q == SUP_GOOD);
endmodule

// File: rtl/cok_output_stage.sv
`timescale 1ns/1ps
// Merges the active-low fault terms and drives the pad controls.
module cok_output_stage (
  input  logic sup_good,
  input  logic brownout,
  input  logic temp_warn,
  input  logic temp_shut,
  output logic chip_ok,
  output logic chip_ok_oe,
  output logic outputs_hiz
);
  logic supply_fine;
  logic thermal_fine;

  assign supply_fine  = sup_good && !brownout;
  assign thermal_fine = !temp_warn && !temp_shut;
  assign chip_ok      = supply_fine && thermal_fine;
  assign outputs_hiz  = temp_shut;
  assign chip_ok_oe   = !temp_shut;
endmodule

// File: rtl/cok_monitor.sv
`timescale 1ns/1ps
module cok_monitor
  import cok_pkg::*;
#(
  parameter int unsigned ASSERT_TICKS  = COK_ASSERT_TICKS_DEF,
  parameter int unsigned RELEASE_TICKS = COK_RELEASE_TICKS_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_1khz,
  input  logic sup_below_trip,
  input  logic sup_above_clear,
  input  logic sup_brownout,
  input  logic temp_warn,
  input  logic temp_shut,
  output logic chip_ok,
  output logic chip_ok_oe,
  output logic outputs_hiz
);
  logic sup_good;

  cok_supply_tracker #(
    .ASSERT_TICKS  (ASSERT_TICKS),
    .RELEASE_TICKS (RELEASE_TICKS)
  ) supply_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick_1khz),
    .below_trip  (sup_below_trip),
    .above_clear (sup_above_clear),
    .brownout    (sup_brownout),
    .sup_good    (sup_good)
  );

  cok_output_stage out_i (
    .sup_good    (sup_good),
    .brownout    (sup_brownout),
    .temp_warn   (temp_warn),
    .temp_shut   (temp_shut),
    .chip_ok     (chip_ok),
    .chip_ok_oe  (chip_ok_oe),
    .outputs_hiz (outputs_hiz)
  );
endmodule

// File: rtl/cok_monitor_chk.sv
`timescale 1ns/1ps
module cok_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_1khz,
  input logic sup_below_trip,
  input logic sup_above_clear,
  input logic sup_brownout,
  input logic temp_warn,
  input logic temp_shut,
  input logic sup_good,
  input logic chip_ok,
  input logic chip_ok_oe,
  input logic outputs_hiz
);
  // R1: the first state after reset is bad
  a_r1_reset_bad: assert property (@(posedge clk)
    !rst_n |=> !sup_good);

  // R2: a good-to-bad change needs the low flag on a tick, or a brownout
  a_r2_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sup_good) |-> $past(sup_brownout) || ($past(sup_below_trip) && $past(tick_1khz)));

  // R3: a bad-to-good change needs the high flag on a tick and no brownout
  a_r3_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sup_good) |-> $past(sup_above_clear) && $past(tick_1khz) && !$past(sup_brownout));

  // R6: brownout leaves the supply state bad
  a_r6_brownout_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sup_brownout |=> !sup_good);

  // R7: the warning trip holds the health level low
  a_r7_warn_low: assert property (@(posedge clk) disable iff (!rst_n)
    temp_warn |-> !chip_ok);

  // R8: the shutdown trip releases the pads
  a_r8_shut_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    temp_shut |-> outputs_hiz && !chip_ok_oe && !chip_ok);

  // R9: without a tick or brownout the supply state does not move
  a_r9_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_1khz && !sup_brownout) |=> $stable(sup_good));
endmodule

bind cok_monitor cok_monitor_chk chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .tick_1khz       (tick_1khz),
  .sup_below_trip  (sup_below_trip),
  .sup_above_clear (sup_above_clear),
  .sup_brownout    (sup_brownout),
  .temp_warn       (temp_warn),
  .temp_shut       (temp_shut),
  .sup_good        (sup_good),
  .chip_ok         (chip_ok),
  .chip_ok_oe      (chip_ok_oe),
  .outputs_hiz     (outputs_hiz)
);

// File: tb/cok_monitor_tb.sv
`timescale 1ns/1ps
module cok_monitor_tb_top;
  localparam int TDIV = 10;       // clocks between ticks in this bench
  localparam int A_T  = 1;
  localparam int R_T  = 6;
  localparam int WD   = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic lo = 1'b0, hi = 1'b0, brown = 1'b0, warn = 1'b0, shut = 1'b0;
  logic chip_ok, chip_ok_oe, outputs_hiz;

  int vectors = 0;
  int fails = 0;
  int tphase = 0;
  bit done = 1'b0;
  string phase = "R1";

  // behavioural reference state
  bit m_good = 1'b0;
  int m_cnt = 0;

  always #5 clk = ~clk;

  cok_monitor #(.ASSERT_TICKS(A_T), .RELEASE_TICKS(R_T)) dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .tick_1khz       (tick),
    .sup_below_trip  (lo),
    .sup_above_clear (hi),
    .sup_brownout    (brown),
    .temp_warn       (warn),
    .temp_shut       (shut),
    .chip_ok         (chip_ok),
    .chip_ok_oe      (chip_ok_oe),
    .outputs_hiz     (outputs_hiz)
  );

  always @(posedge clk) begin
    if (!rst_n || brown) begin
      m_good = 1'b0;
      m_cnt  = 0;
    end else if (!(m_good ? lo : hi)) begin
      m_cnt = 0;
    end else if (tick) begin
      m_cnt = m_cnt + 1;
      if (m_cnt >= (m_good ? A_T : R_T)) begin
        m_good = !m_good;
        m_cnt  = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_ok;
      e_ok = m_good && !brown && !warn && !shut;
      vectors++;
      if (chip_ok !== e_ok || chip_ok_oe !== !shut || outputs_hiz !== shut) begin
        fails++;
        $display("FAIL %s t=%0t ok/oe/hiz got %b%b%b exp %b%b%b", phase, $time,
                 chip_ok, chip_ok_oe, outputs_hiz, e_ok, !shut, shut);
      end
    end
  end

  task automatic cyc();
    @(negedge clk);
    #1;
    tick = (tphase == TDIV - 1);
    tphase = (tphase + 1) % TDIV;
  endtask

  task automatic run_ticks(int k);
    int seen = 0;
    while (seen < k) begin
      cyc();
      if (tick) seen++;
    end
    cyc();
  endtask

  task automatic chk(string req, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t got %b exp %b", req, $time, act, exp);
    end
  endtask

  initial begin
    repeat (4) cyc();
    chk("R1 oe during reset", chip_ok_oe, 1'b1);
    rst_n = 1'b1;
    cyc();
    chk("R1 ok after reset", chip_ok, 1'b0);
    chk("R1 hiz after reset", outputs_hiz, 1'b0);

    phase = "R3"; hi = 1'b1;
    run_ticks(5);
    chk("R3 five ticks", chip_ok, 1'b0);
    run_ticks(1);
    chk("R3 sixth tick", chip_ok, 1'b1);

    phase = "R5"; hi = 1'b0; lo = 1'b0;
    run_ticks(4);
    chk("R5 band holds good", chip_ok, 1'b1);

    phase = "R9"; lo = 1'b1;
    while (tphase != 2) cyc();
    repeat (3) cyc();
    lo = 1'b0;
    cyc();
    chk("R9 low flag without tick", chip_ok, 1'b1);

    phase = "R2"; lo = 1'b1;
    run_ticks(1);
    chk("R2 one tick asserts fault", chip_ok, 1'b0);
    lo = 1'b0;
    run_ticks(3);
    chk("R5 band holds bad", chip_ok, 1'b0);

    phase = "R4"; hi = 1'b1;
    run_ticks(4);
    hi = 1'b0;
    run_ticks(2);
    hi = 1'b1;
    run_ticks(5);
    chk("R4 restart still low", chip_ok, 1'b0);
    run_ticks(1);
    chk("R4 full window releases", chip_ok, 1'b1);

    phase = "R7"; warn = 1'b1;
    cyc();
    chk("R7 warn forces low", chip_ok, 1'b0);
    run_ticks(2);
    warn = 1'b0;
    cyc();
    chk("R7 warn clear restores", chip_ok, 1'b1);

    phase = "R8"; shut = 1'b1;
    cyc();
    chk("R8 hiz set", outputs_hiz, 1'b1);
    chk("R8 oe cleared", chip_ok_oe, 1'b0);
    chk("R8 ok low", chip_ok, 1'b0);
    shut = 1'b0;
    cyc();
    chk("R8 hiz released", outputs_hiz, 1'b0);
    chk("R8 ok restored", chip_ok, 1'b1);

    phase = "R6"; brown = 1'b1; hi = 1'b0;
    cyc();
    chk("R6 brownout low", chip_ok, 1'b0);
    brown = 1'b0; hi = 1'b1;
    run_ticks(4);
    brown = 1'b1;
    cyc();
    brown = 1'b0;
    run_ticks(5);
    chk("R6 count discarded", chip_ok, 1'b0);
    run_ticks(1);
    chk("R6 full release after brownout", chip_ok, 1'b1);

    repeat (3) cyc();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired got running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule